// File: doc/BRIEF.md
# Radix-8 Booth Multiply-Accumulate Unit

This block multiplies two signed two's-complement operands and either loads the product into a wide accumulator or adds it to the running total. The multiplier operand is recoded into radix-8 Booth digits taken from overlapping four-bit windows. The lowest window has an implied zero below bit 0, and each following window starts on the top bit of the window before it. Each digit lies in the range −4..+4 and selects one multiple of the multiplicand: 0, A, 2A, 3A or 4A. The 3A multiple comes from one adder. Negative digits invert the multiple and add a +1 at that digit's weight.

The partial products, the negation corrections and the previous accumulator value all enter a single carry-save tree built from 3:2 compressors. The accumulate therefore needs no adder of its own. One carry-propagate adder resolves the tree output, and the result is registered. A strobe on `in_valid` starts an operation. The registered value and `out_valid` appear on the next clock.

Top module: `booth8_mac`

## Requirements
- R1: When `in_valid` is 1, `acc_en` is 0 and `clr` is 0, `acc_out` on the next clock equals the signed product `op_a × op_b`, sign-extended to ACCW bits.
- R2: When `in_valid` is 1, `acc_en` is 1 and `clr` is 0, `acc_out` on the next clock equals the previous `acc_out` plus the sign-extended signed product, taken modulo 2^ACCW.
- R3: When `in_valid` is 1 and `clr` is 1, `acc_out` on the next clock equals the bare sign-extended product, whatever the value of `acc_en`.
- R4: `out_valid` is 1 exactly in the clock cycle after a cycle in which `in_valid` was 1, and is 0 otherwise.
- R5: When `in_valid` is 0, `acc_out` keeps its value, whatever the values of the operands, `acc_en` and `clr`.
- R6: While `rst_n` is 0, `acc_out` is all zeros and `out_valid` is 0.
- R7: The extreme operands give exact results: −32768 × −32768 = 2^30, −32768 × 32767 = −1073709056, and any product with a zero operand is zero.
- R8: The accumulator is ACCW = 40 bits wide and wraps on overflow. Loading 2^30 and then adding 2^30 another 511 times leaves the bit pattern 0x80_0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| acc_en | input | 1 | Add the product to the accumulator instead of loading it |
| clr | input | 1 | Load the bare product, overriding `acc_en` |
| op_a | input | OPW (16) | Signed multiplicand |
| op_b | input | OPW (16) | Signed multiplier, Booth recoded |
| acc_out | output | ACCW (40) | Accumulated signed result |
| out_valid | output | 1 | `acc_out` was updated on the last clock |

## Verification
The assertions treat `acc_en` and `clr` as meaningful only in cycles where `in_valid` is high. They also assume the inputs carry known values at every rising edge after reset. The bench drives every input on the falling edge, so each value is settled half a period before the edge that samples it. The bench also keeps all control inputs at defined levels on every cycle, including hold cycles, where it deliberately sets `acc_en` and `clr` and changes the operands to show that they have no effect.

// File: rtl/booth8_mac.sv
module booth8_mac #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            acc_en,
  input  logic            clr,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  output logic [ACCW-1:0] acc_out,
  output logic            out_valid
);
  localparam int NDIG = OPW / 3 + 1;
  localparam int EXTW = 3 * NDIG + 1;
  localparam int NOPS = NDIG + 2;
  localparam int NQ   = 3 * NOPS - 4;

  logic [ACCW-1:0] mul1, mul2, mul3, mul4;
  logic [EXTW-1:0] bext;
  logic [ACCW-1:0] pp [NDIG];
  logic [ACCW-1:0] inj;
  logic [ACCW-1:0] q [NQ];
  logic [ACCW-1:0] total;

  assign mul1 = {{(ACCW-OPW){op_a[OPW-1]}}, op_a};
  assign mul2 = mul1 << 1;
  assign mul4 = mul1 << 2;
  assign mul3 = mul1 + mul2;
  assign bext = {{(EXTW-OPW-1){op_b[OPW-1]}}, op_b, 1'b0};

  always_comb begin
    inj = '0;
    for (int d = 0; d < NDIG; d++) begin
      logic [3:0]      win;
      logic [2:0]      t;
      logic [2:0]      mg;
      logic [ACCW-1:0] sel;
      win = bext[3*d +: 4];
      t   = {1'b0, win[2], 1'b0} + {2'b00, win[1]} + {2'b00, win[0]};
      mg  = win[3] ? 3'd4 - t : t;
      case (mg)
        3'd1:    sel = mul1;
        3'd2:    sel = mul2;
        3'd3:    sel = mul3;
        3'd4:    sel = mul4;
        default: sel = '0;
      endcase
      pp[d]    = (win[3] ? ~sel : sel) << (3 * d);
      inj[3*d] = win[3];
    end
  end

  always_comb begin
    for (int i = 0; i < NDIG; i++) q[i] = pp[i];
    q[NDIG]   = inj;
    q[NDIG+1] = (acc_en && !clr) ? acc_out : '0;
    for (int k = 0; k < NOPS - 2; k++) begin
      logic [ACCW-1:0] x, y, z;
      x = q[3*k];
      y = q[3*k+1];
      z = q[3*k+2];
      q[NOPS+2*k]   = x ^ y ^ z;
      q[NOPS+2*k+1] = ((x & y) | (x & z) | (y & z)) << 1;
    end
  end

  assign total = q[NQ-2] + q[NQ-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) acc_out <= total;
    end
  end
endmodule

// File: rtl/booth8_mac_sva.sv
module booth8_mac_sva #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            acc_en,
  input logic            clr,
  input logic [OPW-1:0]  op_a,
  input logic [OPW-1:0]  op_b,
  input logic [ACCW-1:0] acc_out,
  input logic            out_valid
);
  logic [ACCW-1:0] ref_p;
  assign ref_p = $signed({{(ACCW-OPW){op_a[OPW-1]}}, op_a}) *
                 $signed({{(ACCW-OPW){op_b[OPW-1]}}, op_b});

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_en && !clr) |=> acc_out == $past(ref_p));

  p_accum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_en && !clr) |=> acc_out == $past(acc_out) + $past(ref_p));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clr) |=> acc_out == $past(ref_p));

  p_valid_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out));
endmodule

bind booth8_mac booth8_mac_sva #(.OPW(OPW), .ACCW(ACCW)) u_sva (.*);

// File: tb/booth8_mac_tb.sv
module booth8_mac_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPW  = 16;
  localparam int ACCW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, acc_en = 1'b0, clr = 1'b0;
  logic [OPW-1:0] op_a = '0, op_b = '0;
  logic [ACCW-1:0] acc_out;
  logic out_valid;

  int checks = 0;
  int errors = 0;
  logic [ACCW-1:0] exp_acc = '0;
  logic exp_v = 1'b0;
  logic pending = 1'b0;
  string last_tag = "R6";

  always #(CLK_PERIOD/2) clk = ~clk;

  booth8_mac #(.OPW(OPW), .ACCW(ACCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_en(acc_en), .clr(clr),
    .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .out_valid(out_valid)
  );

  task automatic check_now(input string tag);
    checks++;
    if (acc_out !== exp_acc || out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: acc=%h valid=%b expected acc=%h valid=%b",
               tag, acc_out, out_valid, exp_acc, exp_v);
    end
  endtask

  task automatic drive(input logic v, input logic ae, input logic cl,
                       input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                       input string tag);
    longint p;
    @(negedge clk);
    if (pending) check_now(last_tag);
    in_valid = v; acc_en = ae; clr = cl; op_a = a; op_b = b;
    p = longint'($signed(a)) * longint'($signed(b));
    if (v) begin
      if (cl || !ae) exp_acc = ACCW'(p);
      else           exp_acc = exp_acc + ACCW'(p);
    end
    exp_v = v;
    pending = 1'b1;
    last_tag = tag;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R6");
    rst_n = 1'b1;

    drive(1, 0, 0, 16'h8000, 16'h8000, "R7");
    drive(1, 0, 0, 16'h8000, 16'h7fff, "R7");
    drive(1, 0, 0, 16'h0000, 16'h8000, "R7");
    drive(1, 0, 0, 16'h7fff, 16'h0000, "R7");
    drive(1, 0, 0, 16'h7fff, 16'h7fff, "R1");
    drive(1, 0, 0, 16'hffff, 16'h8000, "R1");

    for (int i = 0; i < 65536; i++)
      drive(1, 0, 0, 16'(i * 40503 + 12345), 16'(i), "R1");

    for (int i = 0; i < 65536; i++)
      drive(1, 1, (i % 64) == 0, 16'(i), 16'(i * 7919 + 3), (i % 64) == 0 ? "R3" : "R2");

    drive(1, 1, 1, 16'd1234, 16'hff00, "R3");
    drive(0, 1, 1, 16'h5555, 16'haaaa, "R5");
    drive(0, 0, 0, 16'h8000, 16'h8000, "R5");
    drive(0, 1, 0, 16'h1234, 16'h4321, "R4");
    drive(1, 1, 0, 16'd3, 16'hfffd, "R2");

    drive(1, 1, 1, 16'h8000, 16'h8000, "R3");
    for (int i = 0; i < 511; i++)
      drive(1, 1, 0, 16'h8000, 16'h8000, "R8");
    drive(0, 0, 0, 16'h0000, 16'h0000, "R8");
    @(negedge clk);
    checks++;
    if (acc_out !== 40'h80_0000_0000) begin
      errors++;
      $display("FAIL R8: acc=%h expected acc=%h", acc_out, 40'h80_0000_0000);
    end
    pending = 1'b0;
    drive(1, 1, 0, 16'h8000, 16'h7fff, "R8");
    drive(0, 0, 0, 16'h0000, 16'h0000, "R4");
    drive(0, 0, 0, 16'h0000, 16'h0000, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule